// File: doc/BRIEF.md
# PWM Conversion-Start Event Selector

This block produces two separate conversion-start strobes, channel A and channel B, for an analog converter. Each strobe is driven by the state of a PWM time-base counter. On every clock the block compares the live counter value against zero, against the period and against four compare values. Compare matches can be qualified by the count direction. An external digital-compare event strobe per channel can be used instead of any counter condition.

One 16-bit control word is written through a simple write port and read back in full. For each channel it sets an enable, a 3-bit event source and a bit that moves the compare matches from the A/B pair to the C/D pair.

Each strobe is a single-clock pulse. It fires on the first clock in which the selected condition becomes true, so a counter that sits on a matching value yields one pulse and not a train of pulses.

Top module: `pwm_soc_select`

## Requirements
- R1: After reset the control word reads 0x0000 and both strobes `soc_a` and `soc_b` are low.
- R2: A write stores `reg_wdata` into the control word. `reg_rdata` returns the stored word from the next cycle on. Bit 7 always reads 0 and ignores writes.
- R3: Bit 11 enables channel A and bit 15 enables channel B. While a channel's enable is 0, its strobe stays low whatever the source condition does.
- R4: Source code 000 selects the channel's external event, `dc_evt_a` for channel A and `dc_evt_b` for channel B. Channel A's code sits in bits 10:8 and channel B's code in bits 14:12.
- R5: Code 001 fires when `cnt` equals 0. Code 010 fires when `cnt` equals `prd`.
- R6: Code 011 fires when `cnt` equals 0 or `prd`. When both hold in the same clock (`prd` = 0), only one pulse results.
- R7: Code 100 fires on a compare-A match while counting up (`cnt_down` = 0). Code 101 fires on a compare-A match while counting down (`cnt_down` = 1).
- R8: Code 110 fires on a compare-B match while counting up. Code 111 fires on a compare-B match while counting down.
- R9: When the compare-select bit is 1, codes 100/101 match compare C instead of A, and codes 110/111 match compare D instead of B. The bit is at position 4 for channel A and at position 5 for channel B.
- R10: A strobe goes high in the clock after the one in which the condition first becomes true. It stays high for exactly one clock. A condition held for several clocks gives one pulse.
- R11: Bits 6 and 3:0 are stored and read back as written, and they have no effect on either strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt | input | CNT_W | Time-base counter value |
| cnt_down | input | 1 | 1 while the counter is decrementing |
| prd | input | CNT_W | Period value |
| cmp_a | input | CNT_W | Compare value A |
| cmp_b | input | CNT_W | Compare value B |
| cmp_c | input | CNT_W | Compare value C |
| cmp_d | input | CNT_W | Compare value D |
| dc_evt_a | input | 1 | External compare event for channel A |
| dc_evt_b | input | 1 | External compare event for channel B |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word read-back |
| soc_a | output | 1 | Conversion-start pulse, channel A |
| soc_b | output | 1 | Conversion-start pulse, channel B |

## Verification
The bench holds each matching counter value for a second clock. A design that detects levels instead of rising edges would pulse twice there. It drives a zero-length period so that zero and period hit together; a design that counted each hit separately, or stretched the strobe, would show the strobe high in the following cycle. Every compare code is tried in both directions and with the pair-select bit flipped, so swapped direction qualifiers, swapped compare pairs or a select bit read from the other channel's position would fire on the wrong stimulus. Writing all ones and then loading a word with the spare bits set exposes a bit 7 that can be written, and any stray decoding of the spare bits.

// File: rtl/pwm_soc_pkg.sv
package pwm_soc_pkg;
   localparam int REG_W = 16;
   localparam int N_CH  = 2;

   // channel index 0 is A, 1 is B
   localparam int EN_POS  [N_CH] = '{11, 15};
   localparam int SEL_LSB [N_CH] = '{8, 12};
   localparam int ALT_POS [N_CH] = '{4, 5};
   localparam int RSV_POS = 7;

   localparam logic [REG_W-1:0] WR_MASK = ~(REG_W'(1) << RSV_POS);

   typedef enum logic [2:0] {
      SRC_EXT    = 3'b000,
      SRC_ZERO   = 3'b001,
      SRC_PRD    = 3'b010,
      SRC_ZP     = 3'b011,
      SRC_X_UP   = 3'b100,
      SRC_X_DN   = 3'b101,
      SRC_Y_UP   = 3'b110,
      SRC_Y_DN   = 3'b111
   } soc_src_e;

   typedef struct packed {
      logic     en;
      soc_src_e src;
      logic     alt;
   } ch_cfg_t;
endpackage

// File: rtl/pwm_soc_ctrl_reg.sv
module pwm_soc_ctrl_reg
   import pwm_soc_pkg::*;
#(
   parameter int W = REG_W,
   parameter logic [W-1:0] MASK = W'(WR_MASK)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   if (W < 16) begin : g_chk_w
      $error("pwm_soc_ctrl_reg: W must hold all control fields");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr) begin
         q <= wdata & MASK;
      end
   end
endmodule

// File: rtl/pwm_soc_evt_sel.sv
module pwm_soc_evt_sel
   import pwm_soc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ch_cfg_t          cfg,
   input  logic [CNT_W-1:0] cnt,
   input  logic             cnt_down,
   input  logic [CNT_W-1:0] prd,
   input  logic [CNT_W-1:0] cmp_x,
   input  logic [CNT_W-1:0] cmp_y,
   input  logic [CNT_W-1:0] cmp_x_alt,
   input  logic [CNT_W-1:0] cmp_y_alt,
   input  logic             ext_evt,
   output logic             soc
);
   if (CNT_W < 2) begin : g_chk_cnt
      $error("pwm_soc_evt_sel: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] x_val, y_val;
   logic at_zero, at_prd, hit_x, hit_y;
   logic qual, qual_d;

   always_comb begin
      x_val   = cfg.alt ? cmp_x_alt : cmp_x;
      y_val   = cfg.alt ? cmp_y_alt : cmp_y;
      at_zero = (cnt == '0);
      at_prd  = (cnt == prd);
      hit_x   = (cnt == x_val);
      hit_y   = (cnt == y_val);
      unique case (cfg.src)
         SRC_EXT:  qual = ext_evt;
         SRC_ZERO: qual = at_zero;
         SRC_PRD:  qual = at_prd;
         SRC_ZP:   qual = at_zero | at_prd;
         SRC_X_UP: qual = hit_x & ~cnt_down;
         SRC_X_DN: qual = hit_x &  cnt_down;
         SRC_Y_UP: qual = hit_y & ~cnt_down;
         SRC_Y_DN: qual = hit_y &  cnt_down;
         default:  qual = 1'b0;
      endcase
   end

   // rising edge of the qualified condition gives one pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qual_d <= 1'b0;
         soc    <= 1'b0;
      end else begin
         qual_d <= qual;
         soc    <= cfg.en & qual & ~qual_d;
      end
   end
endmodule

// File: rtl/pwm_soc_select.sv
module pwm_soc_select
   import pwm_soc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic             cnt_down,
   input  logic [CNT_W-1:0] prd,
   input  logic [CNT_W-1:0] cmp_a,
   input  logic [CNT_W-1:0] cmp_b,
   input  logic [CNT_W-1:0] cmp_c,
   input  logic [CNT_W-1:0] cmp_d,
   input  logic             dc_evt_a,
   input  logic             dc_evt_b,
   input  logic             reg_wr,
   input  logic [15:0]      reg_wdata,
   output logic [15:0]      reg_rdata,
   output logic             soc_a,
   output logic             soc_b
);
   if (REG_W != 16) begin : g_chk_reg
      $error("pwm_soc_select: control word must be 16 bits");
   end

   logic [REG_W-1:0] ctrl;
   logic [N_CH-1:0]  soc_v;
   logic [N_CH-1:0]  ext_v;
   logic [CNT_W-1:0] cmp_x_v   [N_CH];
   logic [CNT_W-1:0] cmp_y_v   [N_CH];
   logic [CNT_W-1:0] cmp_xa_v  [N_CH];
   logic [CNT_W-1:0] cmp_ya_v  [N_CH];

   pwm_soc_ctrl_reg #(.W(REG_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .wdata (reg_wdata),
      .q     (ctrl)
   );

   assign ext_v = {dc_evt_b, dc_evt_a};

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      ch_cfg_t cfg;
      assign cfg.en  = ctrl[EN_POS[g]];
      assign cfg.src = soc_src_e'(ctrl[SEL_LSB[g] +: 3]);
      assign cfg.alt = ctrl[ALT_POS[g]];

      // both channels see the same compare set
      assign cmp_x_v[g]  = cmp_a;
      assign cmp_y_v[g]  = cmp_b;
      assign cmp_xa_v[g] = cmp_c;
      assign cmp_ya_v[g] = cmp_d;

      pwm_soc_evt_sel #(.CNT_W(CNT_W)) u_sel (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg       (cfg),
         .cnt       (cnt),
         .cnt_down  (cnt_down),
         .prd       (prd),
         .cmp_x     (cmp_x_v[g]),
         .cmp_y     (cmp_y_v[g]),
         .cmp_x_alt (cmp_xa_v[g]),
         .cmp_y_alt (cmp_ya_v[g]),
         .ext_evt   (ext_v[g]),
         .soc       (soc_v[g])
      );
   end

   assign reg_rdata = ctrl;
   assign soc_a     = soc_v[0];
   assign soc_b     = soc_v[1];
endmodule

// File: rtl/pwm_soc_chk.sv
module pwm_soc_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt,
   input logic             dc_evt_a,
   input logic             dc_evt_b,
   input logic             reg_wr,
   input logic [15:0]      reg_wdata,
   input logic [15:0]      reg_rdata,
   input logic             soc_a,
   input logic             soc_b
);
   // R2: stored word equals written data with bit 7 cleared
   a_r2_write_back: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> reg_rdata == ($past(reg_wdata) & 16'hFF7F));

   // R3: a disabled channel never pulses
   a_r3_off_a: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[11] |=> !soc_a);
   a_r3_off_b: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[15] |=> !soc_b);

   // R4: external source without its strobe stays quiet
   a_r4_ext_a: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[10:8] == 3'b000 && !dc_evt_a) |=> !soc_a);
   a_r4_ext_b: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[14:12] == 3'b000 && !dc_evt_b) |=> !soc_b);

   // R5: zero source cannot fire off zero
   a_r5_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[10:8] == 3'b001 && cnt != '0) |=> !soc_a);

   // R10: pulses last one clock
   a_r10_one_clk_a: assert property (@(posedge clk) disable iff (!rst_n)
      soc_a |=> !soc_a);
   a_r10_one_clk_b: assert property (@(posedge clk) disable iff (!rst_n)
      soc_b |=> !soc_b);
endmodule

bind pwm_soc_select pwm_soc_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt       (cnt),
   .dc_evt_a  (dc_evt_a),
   .dc_evt_b  (dc_evt_b),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .soc_a     (soc_a),
   .soc_b     (soc_b)
);

// File: tb/sim_pwm_soc_select.sv
`timescale 1ns/1ps
module sim_pwm_soc_select;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] cnt, prd, cmp_a, cmp_b, cmp_c, cmp_d;
   logic          cnt_down, dc_evt_a, dc_evt_b, reg_wr;
   logic [15:0]   reg_wdata, reg_rdata;
   logic          soc_a, soc_b;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pwm_soc_select #(.CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_down(cnt_down), .prd(prd),
      .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c), .cmp_d(cmp_d),
      .dc_evt_a(dc_evt_a), .dc_evt_b(dc_evt_b), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .soc_a(soc_a), .soc_b(soc_b)
   );

   task automatic cyc();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_soc(input string req, input logic ea, input logic eb);
      chk({req, " soc_a"}, {15'd0, soc_a}, {15'd0, ea});
      chk({req, " soc_b"}, {15'd0, soc_b}, {15'd0, eb});
   endtask

   task automatic idle();
      cnt = 16'd5; cnt_down = 1'b0; prd = 16'd100;
      dc_evt_a = 1'b0; dc_evt_b = 1'b0;
      cyc();
   endtask

   task automatic wr(input logic [15:0] v);
      reg_wr = 1'b1; reg_wdata = v;
      cyc();
      reg_wr = 1'b0;
      idle();
   endtask

   // drive one counter value and check the pulse, then the held cycle
   task automatic hit(input string req, input logic [CW-1:0] c, input logic dn,
                      input logic ea, input logic eb);
      cnt = c; cnt_down = dn;
      cyc();
      chk_soc(req, ea, eb);
      cyc();
      chk_soc({req, " held"}, 1'b0, 1'b0);
      idle();
   endtask

   task automatic t_reset();
      chk("R1 ctrl", reg_rdata, 16'h0000);
      chk_soc("R1", 1'b0, 1'b0);
   endtask

   task automatic t_regrw();
      wr(16'hFFFF);
      chk("R2 bit7 clear", reg_rdata, 16'hFF7F);
      wr(16'h0080);
      chk("R2 bit7 only", reg_rdata, 16'h0000);
   endtask

   task automatic t_disable();
      wr(16'h1100);
      hit("R3 disabled zero", 16'd0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_zero_prd();
      wr(16'hA900);
      hit("R5 zero on A", 16'd0, 1'b0, 1'b1, 1'b0);
      hit("R5 period on B", 16'd100, 1'b1, 1'b0, 1'b1);
   endtask

   task automatic t_zp();
      wr(16'h0B00);
      hit("R6 period", 16'd100, 1'b0, 1'b1, 1'b0);
      prd = 16'd0;
      cnt = 16'd0;
      cyc();
      chk_soc("R6 zero=period", 1'b1, 1'b0);
      cyc();
      chk_soc("R6 single pulse R10", 1'b0, 1'b0);
      idle();
   endtask

   task automatic t_ext();
      wr(16'h8800);
      dc_evt_a = 1'b1;
      cyc();
      chk_soc("R4 ext A", 1'b1, 1'b0);
      cyc();
      chk_soc("R4 ext A held R10", 1'b0, 1'b0);
      idle();
      dc_evt_b = 1'b1;
      cyc();
      chk_soc("R4 ext B", 1'b0, 1'b1);
      idle();
      hit("R4 counter ignored", 16'd0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_cmp();
      wr(16'h0C00);
      hit("R7 A up", 16'd20, 1'b0, 1'b1, 1'b0);
      hit("R7 A up wrong dir", 16'd20, 1'b1, 1'b0, 1'b0);
      wr(16'h0D00);
      hit("R7 A down", 16'd20, 1'b1, 1'b1, 1'b0);
      wr(16'hE000);
      hit("R8 B up", 16'd30, 1'b0, 1'b0, 1'b1);
      wr(16'hF000);
      hit("R8 B down", 16'd30, 1'b1, 1'b0, 1'b1);
      hit("R8 B down wrong dir", 16'd30, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_cmpsel();
      wr(16'h0C10);
      hit("R9 A alt ignores cmp_a", 16'd20, 1'b0, 1'b0, 1'b0);
      hit("R9 A alt uses cmp_c", 16'd40, 1'b0, 1'b1, 1'b0);
      wr(16'hE020);
      hit("R9 B alt uses cmp_d", 16'd50, 1'b0, 1'b0, 1'b1);
      hit("R9 B alt ignores cmp_b", 16'd30, 1'b0, 1'b0, 1'b0);
      wr(16'hEC10);
      hit("R9 bit4 only on A", 16'd30, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_unused();
      wr(16'h0C4F);
      chk("R11 readback", reg_rdata, 16'h0C4F);
      hit("R11 no effect cmp_a", 16'd20, 1'b0, 1'b1, 1'b0);
      hit("R11 no effect cmp_c", 16'd40, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      cmp_a = 16'd20; cmp_b = 16'd30; cmp_c = 16'd40; cmp_d = 16'd50;
      reg_wr = 1'b0; reg_wdata = '0;
      cnt = 16'd5; cnt_down = 1'b0; prd = 16'd100;
      dc_evt_a = 1'b0; dc_evt_b = 1'b0;
      #3;
      cyc();
      t_reset();
      rst_n = 1'b1;
      idle();
      t_reset();
      t_regrw();
      t_disable();
      t_zero_prd();
      t_zp();
      t_ext();
      t_cmp();
      t_cmpsel();
      t_unused();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule